// File: doc/BRIEF.md
# Cumulative Row Boundary Address Decoder

The block holds one boundary register for each memory row and turns a physical address into the row that holds it. Each register gives the top of its row in 8 MB steps. The rows are laid end to end from address zero, so a row's bottom is the top of the last populated row below it. Software writes the boundaries once at configuration time. It can then read back each row's base and size, and a single flag reports a boundary table whose values run downward.

Address lookups come in with a valid strobe. One clock later the block returns the row index, a hit flag and an out-of-range flag. A boundary that repeats the running top marks an empty row. A zero that follows a populated row stands for the full 2 GB top, so a table can end at the top of the address space with an 8-bit register.

Top module: `row_bound_decoder`

## Requirements
- R1: After reset every boundary register is zero, every row reads back with size zero, `cfg_err` is 0 and `res_valid` is 0.
- R2: A cycle with `cfg_we` high stores `cfg_wdata` into the boundary register selected by `cfg_idx`, and `rd_bnd` returns the register selected by `rd_idx`.
- R3: A row's candidate limit is its boundary value times 2^23 (8 MB). Row 0 starts at address 0, and every other row's base (`rd_base`) is the running top, which is the limit of the last non-empty row below it.
- R4: A row whose candidate limit equals the running top is empty. It reads back with size 0 and never matches an address.
- R5: A boundary of zero read while the running top is nonzero gives a candidate limit of 2^31 (2 GB).
- R6: For an address with base <= address < limit in some non-empty row, `res_hit` is 1 and `res_row` is that row's index. When more than one row would match, the lowest index wins.
- R7: An address at or above the final running top gives `res_oor`=1, `res_hit`=0 and `res_row`=0. When every row is empty, every address is out of range.
- R8: A candidate limit below the running top makes the row empty and leaves the running top unchanged, and `cfg_err` is 1 while any such row exists.
- R9: `res_valid` is high in exactly the cycle after each `req_valid` cycle. The results hold their values until the next request.
- R10: `rd_size` equals the selected row's limit minus its base, so `rd_base + rd_size` is that row's top.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Boundary write enable |
| cfg_idx | input | 3 | Row selected for a write |
| cfg_wdata | input | 8 | Boundary value written, in 8 MB units |
| rd_idx | input | 3 | Row selected for readback |
| rd_bnd | output | 8 | Stored boundary of the selected row |
| rd_base | output | 32 | Base address of the selected row |
| rd_size | output | 32 | Size in bytes of the selected row, 0 when empty |
| cfg_err | output | 1 | Some boundary lies below the running top |
| req_valid | input | 1 | Lookup strobe |
| req_addr | input | 32 | Address to look up |
| res_valid | output | 1 | Result strobe, one cycle after the lookup strobe |
| res_row | output | 3 | Matching row index |
| res_hit | output | 1 | Address falls in a populated row |
| res_oor | output | 1 | Address is at or above the top of memory |

## Verification
The bench aims at the first and last byte of every populated row, where a comparison using <= in place of < moves the address into the neighbouring row. It builds tables with empty rows between populated ones, so that a design which takes the base from the previous register instead of the running top gives rows the wrong base and the wrong size. It also writes a descending boundary, which such a design would turn into a negative-size row that swallows addresses. Trailing zeros after a populated row check the 2 GB case: a design that reads them as zero would declare the upper memory out of range. A table that ends below 2 GB checks the out-of-range edge, and a request one cycle after another checks that results come out in order and on time.

// File: rtl/rbd_pkg.sv
package rbd_pkg;
  localparam int RBD_ROWS       = 8;
  localparam int RBD_BND_W      = 8;
  localparam int RBD_UNIT_SHIFT = 23;
  localparam int RBD_ADDR_W     = 32;
  localparam int RBD_IDX_W      = $clog2(RBD_ROWS);

  typedef logic [RBD_ADDR_W-1:0] rbd_addr_t;

  // Boundary value in units of 2^UNIT_SHIFT bytes, expressed as a byte address.
  function automatic rbd_addr_t rbd_scale(input logic [RBD_BND_W-1:0] bnd);
    rbd_addr_t wide;
    wide = rbd_addr_t'(bnd);
    return wide << RBD_UNIT_SHIFT;
  endfunction

  // The value a zero boundary stands for once memory has started.
  function automatic rbd_addr_t rbd_full_top();
    rbd_addr_t one;
    one = rbd_addr_t'(1);
    return one << (RBD_BND_W + RBD_UNIT_SHIFT);
  endfunction

  // Candidate limit for a row, given the running top below it.
  function automatic rbd_addr_t rbd_candidate(input logic [RBD_BND_W-1:0] bnd,
                                              input rbd_addr_t run_top);
    if (bnd == '0 && run_top != '0) return rbd_full_top();
    return rbd_scale(bnd);
  endfunction
endpackage

// File: rtl/rbd_bank.sv
module rbd_bank #(
  parameter int ROWS  = rbd_pkg::RBD_ROWS,
  parameter int BND_W = rbd_pkg::RBD_BND_W,
  localparam int IDX_W = $clog2(ROWS)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [IDX_W-1:0]           wr_idx,
  input  logic [BND_W-1:0]           wr_data,
  output logic [ROWS-1:0][BND_W-1:0] bnd_q
);
  for (genvar g = 0; g < ROWS; g++) begin : g_reg
    logic sel;
    assign sel = wr_en && (wr_idx == IDX_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   bnd_q[g] <= '0;
      else if (sel) bnd_q[g] <= wr_data;
    end
  end
endmodule

// File: rtl/rbd_span.sv
module rbd_span #(
  parameter int ROWS   = rbd_pkg::RBD_ROWS,
  parameter int BND_W  = rbd_pkg::RBD_BND_W,
  parameter int ADDR_W = rbd_pkg::RBD_ADDR_W
) (
  input  logic [ROWS-1:0][BND_W-1:0]  bnd_q,
  output logic [ROWS-1:0][ADDR_W-1:0] row_base,
  output logic [ROWS-1:0][ADDR_W-1:0] row_limit,
  output logic [ROWS-1:0]             row_empty,
  output logic [ROWS-1:0]             row_order_err,
  output logic [ADDR_W-1:0]           mem_top
);
  import rbd_pkg::*;

  // run[i] is the running top seen by row i; run[ROWS] is the top of memory.
  logic [ROWS:0][ADDR_W-1:0] run;
  assign run[0] = '0;

  for (genvar g = 0; g < ROWS; g++) begin : g_row
    logic [ADDR_W-1:0] cand;
    assign cand             = rbd_candidate(bnd_q[g], run[g]);
    assign row_order_err[g] = cand < run[g];
    assign row_empty[g]     = cand <= run[g];
    assign row_base[g]      = run[g];
    assign row_limit[g]     = row_empty[g] ? run[g] : cand;
    assign run[g+1]         = row_limit[g];
  end

  assign mem_top = run[ROWS];
endmodule

// File: rtl/rbd_match.sv
module rbd_match #(
  parameter int ROWS   = rbd_pkg::RBD_ROWS,
  parameter int ADDR_W = rbd_pkg::RBD_ADDR_W,
  localparam int IDX_W = $clog2(ROWS)
) (
  input  logic [ADDR_W-1:0]           addr,
  input  logic [ROWS-1:0][ADDR_W-1:0] row_base,
  input  logic [ROWS-1:0][ADDR_W-1:0] row_limit,
  input  logic [ROWS-1:0]             row_empty,
  input  logic [ADDR_W-1:0]           mem_top,
  output logic [ROWS-1:0]             hit_vec,
  output logic [IDX_W-1:0]            hit_idx,
  output logic                        any_hit,
  output logic                        beyond_top
);
  for (genvar g = 0; g < ROWS; g++) begin : g_cmp
    assign hit_vec[g] = !row_empty[g] && (addr >= row_base[g]) && (addr < row_limit[g]);
  end

  // Lowest matching index wins.
  always_comb begin
    hit_idx = '0;
    for (int i = ROWS - 1; i >= 0; i--) begin
      if (hit_vec[i]) hit_idx = IDX_W'(i);
    end
  end

  assign any_hit    = |hit_vec;
  assign beyond_top = addr >= mem_top;
endmodule

// File: rtl/row_bound_decoder.sv
module row_bound_decoder #(
  parameter int ROWS   = rbd_pkg::RBD_ROWS,
  parameter int BND_W  = rbd_pkg::RBD_BND_W,
  parameter int ADDR_W = rbd_pkg::RBD_ADDR_W,
  localparam int IDX_W = $clog2(ROWS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic [BND_W-1:0]  cfg_wdata,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [BND_W-1:0]  rd_bnd,
  output logic [ADDR_W-1:0] rd_base,
  output logic [ADDR_W-1:0] rd_size,
  output logic              cfg_err,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              res_valid,
  output logic [IDX_W-1:0]  res_row,
  output logic              res_hit,
  output logic              res_oor
);
  logic [ROWS-1:0][BND_W-1:0]  bnd_q;
  logic [ROWS-1:0][ADDR_W-1:0] row_base;
  logic [ROWS-1:0][ADDR_W-1:0] row_limit;
  logic [ROWS-1:0]             row_empty;
  logic [ROWS-1:0]             row_order_err;
  logic [ADDR_W-1:0]           mem_top;
  logic [ROWS-1:0]             hit_vec;
  logic [IDX_W-1:0]            hit_idx;
  logic                        any_hit;
  logic                        beyond_top;

  rbd_bank #(.ROWS(ROWS), .BND_W(BND_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_we), .wr_idx(cfg_idx),
    .wr_data(cfg_wdata), .bnd_q(bnd_q)
  );

  rbd_span #(.ROWS(ROWS), .BND_W(BND_W), .ADDR_W(ADDR_W)) u_span (
    .bnd_q(bnd_q), .row_base(row_base), .row_limit(row_limit),
    .row_empty(row_empty), .row_order_err(row_order_err), .mem_top(mem_top)
  );

  rbd_match #(.ROWS(ROWS), .ADDR_W(ADDR_W)) u_match (
    .addr(req_addr), .row_base(row_base), .row_limit(row_limit),
    .row_empty(row_empty), .mem_top(mem_top), .hit_vec(hit_vec),
    .hit_idx(hit_idx), .any_hit(any_hit), .beyond_top(beyond_top)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_row   <= '0;
      res_hit   <= 1'b0;
      res_oor   <= 1'b0;
    end else begin
      res_valid <= req_valid;
      if (req_valid) begin
        res_row <= any_hit ? hit_idx : '0;
        res_hit <= any_hit;
        res_oor <= beyond_top;
      end
    end
  end

  assign rd_bnd  = bnd_q[rd_idx];
  assign rd_base = row_base[rd_idx];
  assign rd_size = row_limit[rd_idx] - row_base[rd_idx];
  assign cfg_err = |row_order_err;
endmodule

// File: rtl/rbd_checker.sv
module rbd_checker #(
  parameter int ROWS   = rbd_pkg::RBD_ROWS,
  parameter int ADDR_W = rbd_pkg::RBD_ADDR_W,
  localparam int IDX_W = $clog2(ROWS)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              res_valid,
  input logic [IDX_W-1:0]  res_row,
  input logic              res_hit,
  input logic              res_oor,
  input logic [ROWS-1:0]   hit_vec,
  input logic [ROWS-1:0]   row_empty,
  input logic [ROWS-1:0]   row_order_err
);
  assert_valid_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> res_valid);

  assert_valid_drops_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !res_valid);

  assert_hit_or_oor_R7: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_hit != res_oor));

  assert_miss_row_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_hit) |-> (res_row == '0));

  assert_single_match_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));

  assert_err_row_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (row_order_err & ~row_empty) == '0);

  assert_empty_never_hits_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_vec & row_empty) == '0);
endmodule

bind row_bound_decoder rbd_checker #(.ROWS(ROWS), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .res_valid(res_valid),
  .res_row(res_row), .res_hit(res_hit), .res_oor(res_oor), .hit_vec(hit_vec),
  .row_empty(row_empty), .row_order_err(row_order_err)
);

// File: tb/row_bound_decoder_tb.sv
module row_bound_decoder_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_idx = '0;
  logic [7:0]  cfg_wdata = '0;
  logic [2:0]  rd_idx = '0;
  logic [7:0]  rd_bnd;
  logic [31:0] rd_base;
  logic [31:0] rd_size;
  logic        cfg_err;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic        res_valid;
  logic [2:0]  res_row;
  logic        res_hit;
  logic        res_oor;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  row_bound_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_wdata(cfg_wdata), .rd_idx(rd_idx), .rd_bnd(rd_bnd),
    .rd_base(rd_base), .rd_size(rd_size), .cfg_err(cfg_err),
    .req_valid(req_valid), .req_addr(req_addr), .res_valid(res_valid),
    .res_row(res_row), .res_hit(res_hit), .res_oor(res_oor)
  );

  // Table A boundaries: 2,2,6,4,10,0,0,0
  // {addr, row, hit, oor}
  localparam int NVEC = 10;
  localparam logic [36:0] VEC [NVEC] = '{
    {32'h0000_0000, 3'd0, 1'b1, 1'b0},
    {32'h00FF_FFFF, 3'd0, 1'b1, 1'b0},
    {32'h0100_0000, 3'd2, 1'b1, 1'b0},
    {32'h02FF_FFFF, 3'd2, 1'b1, 1'b0},
    {32'h0300_0000, 3'd4, 1'b1, 1'b0},
    {32'h04FF_FFFF, 3'd4, 1'b1, 1'b0},
    {32'h0500_0000, 3'd5, 1'b1, 1'b0},
    {32'h7FFF_FFFF, 3'd5, 1'b1, 1'b0},
    {32'h8000_0000, 3'd0, 1'b0, 1'b1},
    {32'hFFFF_FFFF, 3'd0, 1'b0, 1'b1}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] idx, input logic [7:0] val);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = idx; cfg_wdata = val;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic load(input logic [7:0] b0, b1, b2, b3, b4, b5, b6, b7);
    wr(3'd0, b0); wr(3'd1, b1); wr(3'd2, b2); wr(3'd3, b3);
    wr(3'd4, b4); wr(3'd5, b5); wr(3'd6, b6); wr(3'd7, b7);
  endtask

  // One lookup; outputs sampled at the falling edge after the capturing edge.
  task automatic look(input string req, input logic [31:0] addr,
                      input logic [2:0] row, input logic hit, input logic oor);
    @(negedge clk);
    req_valid = 1'b1; req_addr = addr;
    @(negedge clk);
    req_valid = 1'b0;
    chk({req, " valid"}, 64'(res_valid), 64'(1));
    chk({req, " row"},   64'(res_row),   64'(row));
    chk({req, " hit"},   64'(res_hit),   64'(hit));
    chk({req, " oor"},   64'(res_oor),   64'(oor));
  endtask

  task automatic rb(input string req, input logic [2:0] idx,
                    input logic [31:0] base, input logic [31:0] size);
    @(negedge clk);
    rd_idx = idx;
    #1;
    chk({req, " base"}, 64'(rd_base), 64'(base));
    chk({req, " size"}, 64'(rd_size), 64'(size));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 res_valid", 64'(res_valid), 64'(0));
    chk("R1 cfg_err", 64'(cfg_err), 64'(0));
    for (int i = 0; i < 8; i++) begin
      rd_idx = 3'(i); #1;
      chk("R1 bnd", 64'(rd_bnd), 64'(0));
      chk("R1 size", 64'(rd_size), 64'(0));
    end
    rst_n = 1'b1;
    // R7: all rows empty, everything out of range
    look("R7 empty table", 32'h0000_0000, 3'd0, 1'b0, 1'b1);

    // Table A
    load(8'd2, 8'd2, 8'd6, 8'd4, 8'd10, 8'd0, 8'd0, 8'd0);
    // R2: readback of stored boundaries
    rd_idx = 3'd4; #1; chk("R2 bnd4", 64'(rd_bnd), 64'(10));
    rd_idx = 3'd3; #1; chk("R2 bnd3", 64'(rd_bnd), 64'(4));
    // R8: descending row 3
    chk("R8 cfg_err", 64'(cfg_err), 64'(1));
    // R3/R4/R5/R8/R10: bases and sizes
    rb("R3 row0", 3'd0, 32'h0000_0000, 32'h0100_0000);
    rb("R4 row1", 3'd1, 32'h0100_0000, 32'h0000_0000);
    rb("R3 row2", 3'd2, 32'h0100_0000, 32'h0200_0000);
    rb("R8 row3", 3'd3, 32'h0300_0000, 32'h0000_0000);
    rb("R10 row4", 3'd4, 32'h0300_0000, 32'h0200_0000);
    rb("R5 row5", 3'd5, 32'h0500_0000, 32'h7B00_0000);
    rb("R4 row6", 3'd6, 32'h8000_0000, 32'h0000_0000);
    // R6/R7/R5: vector walk
    for (int v = 0; v < NVEC; v++) begin
      look("R6 vec", VEC[v][36:5], VEC[v][4:2], VEC[v][1], VEC[v][0]);
    end

    // R9: back-to-back requests, then idle
    @(negedge clk);
    req_valid = 1'b1; req_addr = 32'h0000_0010;
    @(negedge clk);
    req_addr = 32'h0500_0000;
    chk("R9 first valid", 64'(res_valid), 64'(1));
    chk("R9 first row", 64'(res_row), 64'(0));
    @(negedge clk);
    req_valid = 1'b0; req_addr = 32'hFFFF_FFFF;
    chk("R9 second row", 64'(res_row), 64'(5));
    @(negedge clk);
    chk("R9 valid drops", 64'(res_valid), 64'(0));
    chk("R9 row held", 64'(res_row), 64'(5));

    // Table B: leading empties, 2 GB after a full-scale row
    load(8'd0, 8'd0, 8'hFF, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0);
    chk("R8 no err", 64'(cfg_err), 64'(0));
    rb("R5 row3", 3'd3, 32'h7F80_0000, 32'h0080_0000);
    look("R4 leading empty", 32'h0000_0000, 3'd2, 1'b1, 1'b0);
    look("R5 top row", 32'h7F80_0000, 3'd3, 1'b1, 1'b0);

    // Table C: ends below 2 GB
    load(8'd1, 8'd2, 8'd3, 8'd4, 8'd5, 8'd6, 8'd7, 8'd8);
    look("R6 last byte", 32'h03FF_FFFF, 3'd7, 1'b1, 1'b0);
    look("R7 at top", 32'h0400_0000, 3'd0, 1'b0, 1'b1);
    look("R6 row boundary", 32'h0080_0000, 3'd1, 1'b1, 1'b0);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule